// File: doc/BRIEF.md
# Timer-Clocked Asynchronous Serial Port

This block is a full-duplex asynchronous serial transmitter and receiver whose bit timing comes from a tick input rather than from its own baud generator. A neighbouring timer delivers one-cycle pulses on `tick_i`, and every bit lasts a fixed number of those ticks (16 by default). A write on the parallel side starts one outgoing character. Each received character is placed in a holding register, which stays visible on `rd_data_o` until the next one arrives.

An outgoing character is framed as a low start bit, eight bit slots sent least significant bit first, and two high stop bits. When parity is switched on, only seven data bits go out, and the top slot carries odd parity over them. The receiver looks for a falling edge and confirms the start bit halfway through it. It then samples each data bit and the stop bit at their midpoints. With parity on, it replaces the top bit of the stored byte with a parity-error flag. Each direction signals a finished character with its own one-cycle interrupt pulse.

Top module: `tsp_port`

## Requirements
- R1: After reset `txd_o` is 1, both interrupt outputs are 0 and `rd_data_o` is 0; while no character is being sent, `txd_o` stays 1.
- R2: A write with the transmitter idle sends a frame of 11 bit times: a 0 start bit, the eight slots of the byte with bit 0 first, then two 1 stop bits. Each bit time is 16 ticks, and the start bit appears in the cycle after the write.
- R3: With `parity_en_i` = 1, slot 7 of the transmitted frame is odd parity over `wdata_i[6:0]`, so that the eight slots hold an odd number of ones. With `parity_en_i` = 0, slot 7 is `wdata_i[7]`.
- R4: A write while a frame is in progress is ignored. The current frame continues unchanged, and no further frame or interrupt follows it.
- R5: `tx_irq_o` is a one-cycle pulse in the cycle after the last tick of the second stop bit, and there is exactly one pulse per frame.
- R6: A low level on `rxd_i` that is high again at the 8th tick of the start bit is discarded: no interrupt, and `rd_data_o` does not change.
- R7: The receiver samples data bits at their midpoints, bit 0 first. When the stop bit is high at its midpoint, the byte is loaded into `rd_data_o` and `rx_irq_o` pulses for one cycle. `rd_data_o` changes at no other time.
- R8: With `parity_en_i` = 1, bit 7 of the stored byte is 1 when the eight received bits hold an even number of ones (parity error) and 0 otherwise, and bits 6:0 are the received bits. With `parity_en_i` = 0, the received byte is stored unchanged.
- R9: A stop bit that is low at its midpoint discards the character, with no interrupt and `rd_data_o` unchanged. The receiver waits for the line to go high before it accepts a new start bit.
- R10: When a transmit frame and a receive character end on the same tick, both interrupts pulse in the same cycle and neither result is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle timing pulse from the external timer |
| parity_en_i | input | 1 | 1 enables odd parity on transmit and checking on receive |
| wr_i | input | 1 | Write strobe for the transmit byte |
| wdata_i | input | 8 | Byte to transmit |
| rd_data_o | output | 8 | Last received byte (bit 7 is the error flag when parity is on) |
| rxd_i | input | 1 | Serial input |
| txd_o | output | 1 | Serial output, idles high |
| tx_irq_o | output | 1 | Pulse when a frame has been sent |
| rx_irq_o | output | 1 | Pulse when a character has been received |

## Verification
The transmit end of frame and the receive end of character can fall on the same tick, and each raises its own interrupt. The bench starts a transmit frame, counts 24 ticks, and then drives a receive character on `rxd_i`. The receiver's 152-tick path to its stop-bit midpoint then ends on the same tick as the transmitter's 176-tick frame. The check records the cycle of each interrupt pulse and requires the two cycles to be equal. It also requires the received byte and the pulse counts to be correct.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HUNT
  } rx_state_e;
endpackage

// File: rtl/tsp_bit_timer.sv
module tsp_bit_timer #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic mid_o,
  output logic end_o
);
  localparam int CW   = $clog2(TICKS_PER_BIT);
  localparam int HALF = TICKS_PER_BIT / 2;

  logic [CW-1:0] cnt_q;

  assign mid_o = tick_i && (cnt_q == CW'(HALF - 1));
  assign end_o = tick_i && (cnt_q == CW'(TICKS_PER_BIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (end_o)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tsp_sync.sv
module tsp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tsp_tx.sv
module tsp_tx #(
  parameter int DATA_W        = 8,
  parameter int STOP_BITS     = 2,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              parity_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int FRAME_W = 1 + DATA_W + STOP_BITS;
  localparam int IW      = $clog2(FRAME_W);

  logic [FRAME_W-1:0] frame_q;
  logic [IW-1:0]      idx_q;
  logic               busy_q;
  logic               done_q;
  logic               bit_end;
  logic [DATA_W-1:0]  payload;
  logic               load;

  assign load = wr_i && !busy_q;

  always_comb begin
    payload = wdata_i;
    if (parity_en_i) payload[DATA_W-1] = ~(^wdata_i[DATA_W-2:0]);
  end

  tsp_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!busy_q),
    .tick_i (tick_i),
    .mid_o  (),
    .end_o  (bit_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '1;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        frame_q <= {{STOP_BITS{1'b1}}, payload, 1'b0};
        idx_q   <= '0;
        busy_q  <= 1'b1;
      end else if (busy_q && bit_end) begin
        frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
        if (idx_q == IW'(FRAME_W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign txd_o  = busy_q ? frame_q[0] : 1'b1;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/tsp_rx.sv
module tsp_rx
  import tsp_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              parity_en_i,
  input  logic              rxd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  localparam int BW = $clog2(DATA_W);

  rx_state_e         state_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] data_q;
  logic [BW-1:0]     bit_q;
  logic              done_q;
  logic              mid, bit_end, clr;
  logic [DATA_W-1:0] stored;

  // restart the bit timer at the start-bit midpoint so later samples land mid-bit
  assign clr = (state_q == RX_IDLE) || (state_q == RX_HUNT) ||
               ((state_q == RX_START) && mid);

  tsp_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .tick_i (tick_i),
    .mid_o  (mid),
    .end_o  (bit_end)
  );

  always_comb begin
    stored = sh_q;
    if (parity_en_i) stored[DATA_W-1] = ~(^sh_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      sh_q    <= '0;
      data_q  <= '0;
      bit_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        RX_IDLE:  if (!rxd_i) state_q <= RX_START;
        RX_START: if (mid) begin
          if (rxd_i) state_q <= RX_IDLE;
          else begin
            state_q <= RX_DATA;
            bit_q   <= '0;
          end
        end
        RX_DATA: if (bit_end) begin
          sh_q <= {rxd_i, sh_q[DATA_W-1:1]};
          if (bit_q == BW'(DATA_W - 1)) state_q <= RX_STOP;
          else                          bit_q   <= bit_q + 1'b1;
        end
        RX_STOP: if (bit_end) begin
          if (rxd_i) begin
            data_q  <= stored;
            done_q  <= 1'b1;
            state_q <= RX_IDLE;
          end else begin
            state_q <= RX_HUNT;
          end
        end
        RX_HUNT:  if (rxd_i) state_q <= RX_IDLE;
        default:  state_q <= RX_IDLE;
      endcase
    end
  end

  assign data_o = data_q;
  assign done_o = done_q;
endmodule

// File: rtl/tsp_port.sv
module tsp_port #(
  parameter int DATA_W        = 8,
  parameter int STOP_BITS     = 2,
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              parity_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              tx_irq_o,
  output logic              rx_irq_o
);
  logic rxd_s;
  logic tx_busy;

  tsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rxd_i),
    .q_o    (rxd_s)
  );

  tsp_tx #(
    .DATA_W        (DATA_W),
    .STOP_BITS     (STOP_BITS),
    .TICKS_PER_BIT (TICKS_PER_BIT)
  ) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .parity_en_i (parity_en_i),
    .wr_i        (wr_i),
    .wdata_i     (wdata_i),
    .txd_o       (txd_o),
    .busy_o      (tx_busy),
    .done_o      (tx_irq_o)
  );

  tsp_rx #(
    .DATA_W        (DATA_W),
    .TICKS_PER_BIT (TICKS_PER_BIT)
  ) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .parity_en_i (parity_en_i),
    .rxd_i       (rxd_s),
    .data_o      (rd_data_o),
    .done_o      (rx_irq_o)
  );
endmodule

// File: rtl/tsp_port_chk.sv
module tsp_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              txd_o,
  input logic              tx_irq_o,
  input logic              rx_irq_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              tx_busy
);
  a_r1_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> txd_o);

  a_r2_start_bit_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy) |-> !txd_o);

  a_r4_frame_only_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy) |-> $past(wr_i));

  a_r5_tx_irq_at_frame_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> $fell(tx_busy));

  a_r5_tx_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |=> !tx_irq_o);

  a_r7_rx_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |=> !rx_irq_o);

  a_r7_data_changes_with_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_data_o) |-> rx_irq_o);
endmodule

bind tsp_port tsp_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .txd_o     (txd_o),
  .tx_irq_o  (tx_irq_o),
  .rx_irq_o  (rx_irq_o),
  .rd_data_o (rd_data_o),
  .tx_busy   (tx_busy)
);

// File: tb/tsp_port_bench.sv
module tsp_port_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i;
  logic       parity_en_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rd_data_o;
  logic       rxd_i;
  logic       txd_o, tx_irq_o, rx_irq_o;
  logic       loop_en = 1'b0;
  logic       rxd_drv = 1'b1;
  logic [1:0] tick_div = '0;

  int checks = 0, failures = 0;
  int cyc = 0, tick_seen = 0;
  int tx_cnt = 0, rx_cnt = 0, tx_cyc = 0, rx_cyc = 0;

  // {parity_en, wdata, expected slots 7:0 on the line, expected rd_data in loopback}
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 8'hA5, 8'hA5, 8'hA5},
    {1'b0, 8'h00, 8'h00, 8'h00},
    {1'b1, 8'h81, 8'h01, 8'h01},
    {1'b1, 8'h03, 8'h83, 8'h03},
    {1'b1, 8'h7F, 8'h7F, 8'h7F},
    {1'b0, 8'hFF, 8'hFF, 8'hFF}
  };

  always #5 clk_i = ~clk_i;
  always @(negedge clk_i) tick_div <= tick_div + 1'b1;
  assign tick_i = (tick_div == 2'd0);
  assign rxd_i  = loop_en ? txd_o : rxd_drv;

  tsp_port u_tsp_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .parity_en_i (parity_en_i),
    .wr_i        (wr_i),
    .wdata_i     (wdata_i),
    .rd_data_o   (rd_data_o),
    .rxd_i       (rxd_i),
    .txd_o       (txd_o),
    .tx_irq_o    (tx_irq_o),
    .rx_irq_o    (rx_irq_o)
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (tick_i) tick_seen <= tick_seen + 1;
  end

  always @(negedge clk_i) begin
    if (tx_irq_o) begin tx_cnt <= tx_cnt + 1; tx_cyc <= cyc; end
    if (rx_irq_o) begin rx_cnt <= rx_cnt + 1; rx_cyc <= cyc; end
  end

  always @(negedge clk_i) if (cyc > 100000) begin
    $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int t0 = tick_seen;
    while (tick_seen < t0 + n) @(negedge clk_i);
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk_i);
    wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  // samples the line at every bit midpoint; optionally writes again while busy
  task automatic capture_frame(output logic [10:0] got, input bit extra_wr);
    wait_ticks(8);
    for (int i = 0; i < 11; i++) begin
      got[i] = txd_o;
      if (extra_wr && i == 3) write_byte(8'hC3);
      if (i < 10) wait_ticks(16);
    end
  endtask

  task automatic drive_rx(input logic [7:0] d, input bit stop_ok);
    rxd_drv = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < 8; i++) begin
      rxd_drv = d[i];
      wait_ticks(16);
    end
    rxd_drv = stop_ok;
    wait_ticks(16);
    if (!stop_ok) begin
      wait_ticks(16);
      rxd_drv = 1'b1;
    end
    wait_ticks(4);
  endtask

  initial begin
    logic [10:0] got;
    int t0, r0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 txd idle", 32'(txd_o), 32'd1);
    check("R1 irqs low", 32'({tx_irq_o, rx_irq_o}), 32'd0);
    check("R1 rd_data", 32'(rd_data_o), 32'd0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R1 txd idle after reset", 32'(txd_o), 32'd1);

    // table: loopback frames, R2 R3 R5 R7 R8
    loop_en = 1'b1;
    for (int v = 0; v < 6; v++) begin
      parity_en_i = VEC[v][24];
      t0 = tx_cnt; r0 = rx_cnt;
      write_byte(VEC[v][23:16]);
      capture_frame(got, 1'b0);
      check("R2 R3 tx frame", 32'(got), 32'({2'b11, VEC[v][15:8], 1'b0}));
      wait_ticks(12);
      check("R5 one tx irq", 32'(tx_cnt - t0), 32'd1);
      check("R7 R8 loopback rx", 32'({rx_cnt - r0 == 1, rd_data_o}), 32'({1'b1, VEC[v][7:0]}));
    end
    loop_en = 1'b0;

    // R4 write while busy is ignored
    parity_en_i = 1'b0;
    t0 = tx_cnt;
    write_byte(8'h3C);
    capture_frame(got, 1'b1);
    check("R4 frame unchanged", 32'(got), 32'({2'b11, 8'h3C, 1'b0}));
    wait_ticks(200);
    check("R4 no second frame", 32'({tx_cnt - t0, 1'b0, txd_o}), 32'({32'd1, 1'b0, 1'b1}));

    // R7 plain receive, R8 parity error and clean parity
    r0 = rx_cnt;
    drive_rx(8'hC4, 1'b1);
    check("R7 rx byte", 32'({rx_cnt - r0 == 1, rd_data_o}), 32'({1'b1, 8'hC4}));
    parity_en_i = 1'b1;
    drive_rx(8'h03, 1'b1);
    check("R8 parity error flag", 32'(rd_data_o), 32'h83);
    drive_rx(8'h07, 1'b1);
    check("R8 parity ok", 32'(rd_data_o), 32'h07);
    parity_en_i = 1'b0;

    // R6 glitch shorter than half a bit
    r0 = rx_cnt;
    rxd_drv = 1'b0;
    wait_ticks(4);
    rxd_drv = 1'b1;
    wait_ticks(200);
    check("R6 glitch discarded", 32'({rx_cnt - r0, rd_data_o}), 32'({32'd0, 8'h07}));

    // R9 bad stop, then recovery
    r0 = rx_cnt;
    drive_rx(8'h55, 1'b0);
    wait_ticks(20);
    check("R9 bad stop discarded", 32'({rx_cnt - r0, rd_data_o}), 32'({32'd0, 8'h07}));
    drive_rx(8'h5A, 1'b1);
    check("R9 recovery", 32'({rx_cnt - r0, rd_data_o}), 32'({32'd1, 8'h5A}));

    // R10 both completions on the same tick
    t0 = tx_cnt; r0 = rx_cnt;
    write_byte(8'h96);
    wait_ticks(24);
    drive_rx(8'h69, 1'b1);
    wait_ticks(30);
    check("R10 irq counts", 32'({tx_cnt - t0, rx_cnt - r0}), 32'({32'd1, 32'd1}));
    check("R10 same cycle", 32'(tx_cyc - rx_cyc), 32'd0);
    check("R10 rx byte", 32'(rd_data_o), 32'h69);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule